// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each valid operation reads two 16-bit operands and one of two 40-bit accumulators, and writes its result back into that same accumulator in the next clock edge. Inside the block there is one 17x17 signed multiplier, a barrel shifter that works on accumulator values, and a wide adder. A saturation stage sits after the adder, and after it comes a rounder that produces a 16-bit word for memory writeback. Operand fetch and address generation belong to the surrounding pipeline.

Static configuration pins set several behaviours. They choose integer or fractional products and signed or unsigned operands. They choose conventional or convergent (ties-to-even) rounding of the writeback word. They enable saturation separately for accumulator A, for accumulator B and for the writeback word. A further pin picks where the accumulators clip: at the 32-bit boundary or at the full 40-bit boundary. The block raises a sticky flag for each accumulator whenever that accumulator clips, and a live flag whenever an accumulator holds a value that cannot be represented in 32 bits.

The block has no state machine. The one sequential stage is the set of registers that is updated on every valid operation. The operation code is decoded combinationally into a candidate value 56 bits wide. That value then passes through the clipping stage and the rounder.

Top module: `dsp_mac_engine`

## Requirements
- R1: After reset both accumulators are zero, and every flag and the writeback word are zero.
- R2: Code 2 loads the target with x*y and code 3 loads it with -(x*y). When `cfg_unsigned`=1 the operands are zero-extended, otherwise they are sign-extended. When `cfg_frac`=1 the product is doubled.
- R3: Code 4 adds the product to the target and code 5 subtracts it.
- R4: Code 6 loads the target with (x-y)^2 and code 7 adds (x-y)^2 to it. The same extension and fractional rules as R2 apply.
- R5: Code 1 clears the target and its sticky flag. Code 0 and codes 12 to 15 leave both accumulators and both sticky flags unchanged, yet still write back the target.
- R6: Code 8 sets the target to A+B. Code 9 sets it to target minus the other accumulator. Code 10 sets it to minus the target.
- R7: Code 11 shifts the target arithmetically by the signed `shift_amt`, where a positive value shifts left. The amount is clamped to the range -16..+16. `shift_ovf` becomes 1 when the shifted value does not fit in 40 bits.
- R8: When saturation is enabled for the target, an out-of-range result clips and sets that accumulator's sticky flag. With `cfg_sat_wide`=1 the limits are 0x7FFFFFFFFF and 0x8000000000. With `cfg_sat_wide`=0 the limits are 0x007FFFFFFF and 0xFF80000000. The sticky flag stays set until a clear (code 1) of that accumulator.
- R9: When saturation is disabled for the target, results wrap modulo 2^40 and no sticky flag is set.
- R10: `ovf_a` and `ovf_b` are 1 exactly when bits 39 down to 31 of that accumulator are not all equal.
- R11: The writeback word is bits 31:16 of the new target value after rounding at bit 15. A remainder above half rounds up and a remainder below half rounds down. An exact half rounds up when `cfg_conv_round`=0, and when `cfg_conv_round`=1 it rounds to the even word.
- R12: With `cfg_sat_wb`=1, a rounded value outside the 32-bit signed range gives 0x7FFF or 0x8000 and sets `wb_clamped`.
- R13: While `op_valid`=0 nothing changes. An operation only changes the accumulator selected by `acc_sel` (0 selects A, 1 selects B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator (0 = A, 1 = B) |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| shift_amt | input | 6 | Signed shift amount for code 11 |
| cfg_frac | input | 1 | Fractional product (doubled) |
| cfg_unsigned | input | 1 | Zero-extend operands |
| cfg_conv_round | input | 1 | Ties-to-even writeback rounding |
| cfg_sat_a | input | 1 | Saturation enable for A |
| cfg_sat_b | input | 1 | Saturation enable for B |
| cfg_sat_wb | input | 1 | Saturation enable for writeback word |
| cfg_sat_wide | input | 1 | 1 = clip at 40 bits, 0 = clip at 32 bits |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| wb_word | output | 16 | Rounded writeback word of last target |
| wb_clamped | output | 1 | Writeback word was clipped |
| ovf_a | output | 1 | A exceeds the 32-bit range |
| ovf_b | output | 1 | B exceeds the 32-bit range |
| sat_a | output | 1 | Sticky clip flag of A |
| sat_b | output | 1 | Sticky clip flag of B |
| shift_ovf | output | 1 | Last shift lost significant bits |

## Verification
Two situations are hard to reach from the ports. The first is an exact rounding tie, where the low 16 bits of the accumulator are precisely 0x8000. The bench builds it with integer products whose low bits are fixed, such as 0x0080*0x0100 and 0x0180*0x0100, so that the even and odd neighbouring words are both met. The second is clipping at the full 40-bit limit, which multiplies alone cannot reach. The bench first loads a large fractional product and then shifts it left by 16 twice, with saturation enabled in one run and disabled in another.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

    typedef enum logic [3:0] {
        OP_HOLD  = 4'd0,
        OP_CLR   = 4'd1,
        OP_MPY   = 4'd2,
        OP_MPYN  = 4'd3,
        OP_MAC   = 4'd4,
        OP_MSC   = 4'd5,
        OP_SQD   = 4'd6,
        OP_SQDAC = 4'd7,
        OP_ADD   = 4'd8,
        OP_SUB   = 4'd9,
        OP_NEG   = 4'd10,
        OP_SHIFT = 4'd11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]          x_i,
    input  logic [DATA_W-1:0]          y_i,
    input  logic                       uns_i,
    input  logic                       frac_i,
    input  logic                       square_i,
    output logic signed [2*DATA_W+2:0] prod_o
);
    localparam int MUL_W = DATA_W + 1;

    logic signed [MUL_W-1:0]   xe, ye, diff, op_a, op_b;
    logic signed [2*MUL_W-1:0] raw;

    always_comb begin
        xe   = {~uns_i & x_i[DATA_W-1], x_i};
        ye   = {~uns_i & y_i[DATA_W-1], y_i};
        diff = xe - ye;
        op_a = square_i ? diff : xe;
        op_b = square_i ? diff : ye;
        raw  = op_a * op_b;
        prod_o = frac_i ? {raw, 1'b0} : {raw[2*MUL_W-1], raw};
    end
endmodule

// File: rtl/mac_shifter.sv
module mac_shifter #(
    parameter int ACC_W     = 40,
    parameter int SHIFT_MAX = 16,
    parameter int AMT_W     = 6
) (
    input  logic signed [ACC_W-1:0]           acc_i,
    input  logic signed [AMT_W-1:0]           amt_i,
    output logic signed [ACC_W+SHIFT_MAX-1:0] wide_o
);
    localparam int WIDE_W = ACC_W + SHIFT_MAX;

    int                      amt;
    logic signed [WIDE_W-1:0] ext;

    always_comb begin
        amt = int'(amt_i);
        if (amt > SHIFT_MAX)  amt = SHIFT_MAX;
        if (amt < -SHIFT_MAX) amt = -SHIFT_MAX;
        ext = {{SHIFT_MAX{acc_i[ACC_W-1]}}, acc_i};
        if (amt >= 0) wide_o = ext <<< amt;
        else          wide_o = ext >>> (-amt);
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int ACC_W    = 40,
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 56
) (
    input  logic signed [WIDE_W-1:0] cand_i,
    input  logic                     en_i,
    input  logic                     wide_mode_i,
    output logic [ACC_W-1:0]         acc_o,
    output logic                     clamp_o,
    output logic                     fits_o
);
    localparam logic [ACC_W-1:0] WIDE_POS = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] WIDE_NEG = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] NAR_POS  = {{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NAR_NEG  = {{(ACC_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic fits_full, fits_narrow, in_limit, neg;

    always_comb begin
        fits_full   = (&cand_i[WIDE_W-1:ACC_W-1])    | ~(|cand_i[WIDE_W-1:ACC_W-1]);
        fits_narrow = (&cand_i[WIDE_W-1:NARROW_W-1]) | ~(|cand_i[WIDE_W-1:NARROW_W-1]);
        in_limit    = wide_mode_i ? fits_full : fits_narrow;
        neg         = cand_i[WIDE_W-1];
        fits_o      = fits_full;
        clamp_o     = en_i && !in_limit;
        if (clamp_o) begin
            if (wide_mode_i) acc_o = neg ? WIDE_NEG : WIDE_POS;
            else             acc_o = neg ? NAR_NEG  : NAR_POS;
        end else begin
            acc_o = cand_i[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/mac_wb.sv
module mac_wb #(
    parameter int ACC_W  = 40,
    parameter int DATA_W = 16
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              conv_i,
    input  logic              sat_i,
    output logic [DATA_W-1:0] word_o,
    output logic              clamp_o
);
    localparam int NARROW_W = 2 * DATA_W;

    logic signed [ACC_W:0] ext, rnd;
    logic tie, up, in_range;

    always_comb begin
        ext      = {acc_i[ACC_W-1], acc_i};
        tie      = acc_i[DATA_W-1] && ~(|acc_i[DATA_W-2:0]);
        up       = acc_i[DATA_W-1] && !(conv_i && tie && !acc_i[DATA_W]);
        rnd      = ext + ((ACC_W+1)'(up) << DATA_W);
        in_range = (&rnd[ACC_W:NARROW_W-1]) | ~(|rnd[ACC_W:NARROW_W-1]);
        clamp_o  = sat_i && !in_range;
        if (clamp_o) word_o = rnd[ACC_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        else         word_o = rnd[NARROW_W-1:DATA_W];
    end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
    import dsp_mac_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int DATA_W    = 16,
    parameter int SHIFT_MAX = 16,
    parameter int AMT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              cfg_frac,
    input  logic              cfg_unsigned,
    input  logic              cfg_conv_round,
    input  logic              cfg_sat_a,
    input  logic              cfg_sat_b,
    input  logic              cfg_sat_wb,
    input  logic              cfg_sat_wide,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic [DATA_W-1:0] wb_word,
    output logic              wb_clamped,
    output logic              ovf_a,
    output logic              ovf_b,
    output logic              sat_a,
    output logic              sat_b,
    output logic              shift_ovf
);
    localparam int NARROW_W = 2 * DATA_W;
    localparam int WIDE_W   = ACC_W + SHIFT_MAX;
    localparam int PROD_W   = 2 * DATA_W + 3;
    localparam int N_ACC    = 2;

    mac_op_e op;
    logic [ACC_W-1:0]   acc_q [N_ACC];
    logic [N_ACC-1:0]   sat_q;
    logic [N_ACC-1:0]   ovf_w;
    logic [DATA_W-1:0]  wb_q;
    logic               wbc_q, shf_q;

    logic [ACC_W-1:0]         tgt, oth, nxt_acc;
    logic signed [WIDE_W-1:0] tgt_w, oth_w, prod_w, shf_w, cand;
    logic signed [PROD_W-1:0] prod;
    logic square, changes, sat_en, clamp, fits;
    logic [DATA_W-1:0] wb_nxt;
    logic wbc_nxt;

    function automatic logic signed [WIDE_W-1:0] widen(input logic [ACC_W-1:0] v);
        return {{SHIFT_MAX{v[ACC_W-1]}}, v};
    endfunction

    assign op     = mac_op_e'(op_code);
    assign tgt    = acc_q[acc_sel];
    assign oth    = acc_q[~acc_sel];
    assign tgt_w  = widen(tgt);
    assign oth_w  = widen(oth);
    assign square = (op == OP_SQD) || (op == OP_SQDAC);
    assign prod_w = {{(WIDE_W-PROD_W){prod[PROD_W-1]}}, prod};

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .x_i(x_in), .y_i(y_in), .uns_i(cfg_unsigned), .frac_i(cfg_frac),
        .square_i(square), .prod_o(prod)
    );

    mac_shifter #(.ACC_W(ACC_W), .SHIFT_MAX(SHIFT_MAX), .AMT_W(AMT_W)) u_shift (
        .acc_i(tgt), .amt_i(shift_amt), .wide_o(shf_w)
    );

    // Operation decode into a wide candidate value
    always_comb begin
        changes = 1'b1;
        unique case (op)
            OP_HOLD:         begin cand = tgt_w; changes = 1'b0; end
            OP_CLR:          cand = '0;
            OP_MPY, OP_SQD:  cand = prod_w;
            OP_MPYN:         cand = -prod_w;
            OP_MAC, OP_SQDAC: cand = tgt_w + prod_w;
            OP_MSC:          cand = tgt_w - prod_w;
            OP_ADD:          cand = tgt_w + oth_w;
            OP_SUB:          cand = tgt_w - oth_w;
            OP_NEG:          cand = -tgt_w;
            OP_SHIFT:        cand = shf_w;
            default:         begin cand = tgt_w; changes = 1'b0; end
        endcase
    end

    assign sat_en = changes && (acc_sel ? cfg_sat_b : cfg_sat_a);

    mac_sat #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sat (
        .cand_i(cand), .en_i(sat_en), .wide_mode_i(cfg_sat_wide),
        .acc_o(nxt_acc), .clamp_o(clamp), .fits_o(fits)
    );

    mac_wb #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_wb (
        .acc_i(nxt_acc), .conv_i(cfg_conv_round), .sat_i(cfg_sat_wb),
        .word_o(wb_nxt), .clamp_o(wbc_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
            sat_q <= '0;
            wb_q  <= '0;
            wbc_q <= 1'b0;
            shf_q <= 1'b0;
        end else if (op_valid) begin
            acc_q[acc_sel] <= nxt_acc;
            sat_q[acc_sel] <= (op == OP_CLR) ? 1'b0 : (sat_q[acc_sel] | clamp);
            wb_q  <= wb_nxt;
            wbc_q <= wbc_nxt;
            shf_q <= (op == OP_SHIFT) && !fits;
        end
    end

    generate
        for (genvar g = 0; g < N_ACC; g++) begin : g_ovf
            assign ovf_w[g] = ~((&acc_q[g][ACC_W-1:NARROW_W-1]) | ~(|acc_q[g][ACC_W-1:NARROW_W-1]));
        end
    endgenerate

    // Outputs
    always_comb begin
        acc_a      = acc_q[0];
        acc_b      = acc_q[1];
        sat_a      = sat_q[0];
        sat_b      = sat_q[1];
        ovf_a      = ovf_w[0];
        ovf_b      = ovf_w[1];
        wb_word    = wb_q;
        wb_clamped = wbc_q;
        shift_ovf  = shf_q;
    end

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

    p_other_acc_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> $stable(acc_b));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && op_code == 4'd1) |=> (acc_a == '0 && !sat_a));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_a && !(op_valid && !acc_sel && op_code == 4'd1)) |=> sat_a);

    p_narrow_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && clamp && !cfg_sat_wide) |=> !ovf_a);

    p_wb_limits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_clamped |-> (wb_word == {1'b0, {(DATA_W-1){1'b1}}} || wb_word == {1'b1, {(DATA_W-1){1'b0}}}));

    p_shift_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_ovf) |-> $past(op_code) == 4'd11);
endmodule

// File: tb/dsp_mac_engine_bench.sv
`timescale 1ns/1ps
module dsp_mac_engine_bench;
    logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, acc_sel = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] x_in = '0, y_in = '0;
    logic [5:0]  shift_amt = '0;
    logic c_frac = 0, c_uns = 0, c_conv = 0, c_sat_a = 0, c_sat_b = 0, c_sat_wb = 0, c_wide = 0;
    logic [39:0] acc_a, acc_b;
    logic [15:0] wb_word;
    logic wb_clamped, ovf_a, ovf_b, sat_a, sat_b, shift_ovf;

    int n_chk = 0, n_fail = 0;
    longint m_acc [2];
    bit     m_sat [2];
    logic [15:0] m_wb;
    bit     m_wbc, m_shf;

    always #2.5 clk = ~clk;

    dsp_mac_engine u_dsp_mac_engine (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel),
        .x_in(x_in), .y_in(y_in), .shift_amt(shift_amt), .cfg_frac(c_frac), .cfg_unsigned(c_uns),
        .cfg_conv_round(c_conv), .cfg_sat_a(c_sat_a), .cfg_sat_b(c_sat_b), .cfg_sat_wb(c_sat_wb),
        .cfg_sat_wide(c_wide), .acc_a(acc_a), .acc_b(acc_b), .wb_word(wb_word),
        .wb_clamped(wb_clamped), .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b),
        .shift_ovf(shift_ovf)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic longint ext(input logic [15:0] v);
        return c_uns ? longint'(v) : longint'($signed(v));
    endfunction

    function automatic bit big32(input longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic model(input int oc, input bit sel, input logic [15:0] x, y, input int sh);
        longint t, o, p, c, d, hi, lo, nv, q, rem;
        logic [39:0] w;
        bit ch, en, clip;
        int n;
        t = m_acc[sel]; o = m_acc[!sel]; ch = 1; clip = 0;
        if (oc == 6 || oc == 7) begin d = ext(x) - ext(y); p = d * d; end
        else p = ext(x) * ext(y);
        if (c_frac) p = p * 2;
        n = sh; if (n > 16) n = 16; if (n < -16) n = -16;
        case (oc)
            1: c = 0;
            2, 6: c = p;
            3: c = -p;
            4, 7: c = t + p;
            5: c = t - p;
            8: c = m_acc[0] + m_acc[1];
            9: c = t - o;
            10: c = -t;
            11: c = (n >= 0) ? (t <<< n) : (t >>> (-n));
            default: begin c = t; ch = 0; end
        endcase
        hi = c_wide ? 64'sd549755813887 : 64'sd2147483647;
        lo = -hi - 1;
        en = ch && (sel ? c_sat_b : c_sat_a);
        if (en && (c > hi || c < lo)) begin nv = (c > hi) ? hi : lo; clip = 1; end
        else begin w = c[39:0]; nv = longint'($signed(w)); end
        m_shf = (oc == 11) && (c > 64'sd549755813887 || c < -64'sd549755813888);
        m_sat[sel] = (oc == 1) ? 1'b0 : (m_sat[sel] | clip);
        m_acc[sel] = nv;
        q = nv >>> 16; rem = nv & 64'hFFFF;
        if (rem > 64'h8000 || (rem == 64'h8000 && (!c_conv || q[0]))) q = q + 1;
        m_wbc = c_sat_wb && (q > 32767 || q < -32768);
        if (m_wbc) m_wb = (q > 0) ? 16'h7FFF : 16'h8000;
        else m_wb = q[15:0];
    endtask

    task automatic compare(input string tag);
        chk(tag, "acc_a", longint'($signed(acc_a)), m_acc[0]);
        chk(tag, "acc_b", longint'($signed(acc_b)), m_acc[1]);
        chk(tag, "sat_a", longint'(sat_a), longint'(m_sat[0]));
        chk(tag, "sat_b", longint'(sat_b), longint'(m_sat[1]));
        chk(tag, "ovf_a", longint'(ovf_a), longint'(big32(m_acc[0])));
        chk(tag, "ovf_b", longint'(ovf_b), longint'(big32(m_acc[1])));
        chk(tag, "wb_word", longint'(wb_word), longint'(m_wb));
        chk(tag, "wb_clamped", longint'(wb_clamped), longint'(m_wbc));
        chk(tag, "shift_ovf", longint'(shift_ovf), longint'(m_shf));
    endtask

    task automatic do_op(input int oc, input bit sel, input logic [15:0] x, y, input int sh, input string tag);
        @(negedge clk);
        op_valid = 1; op_code = 4'(oc); acc_sel = sel; x_in = x; y_in = y; shift_amt = 6'(sh);
        model(oc, sel, x, y, sh);
        @(negedge clk);
        op_valid = 0;
        compare(tag);
    endtask

    task automatic t_reset;
        m_acc[0] = 0; m_acc[1] = 0; m_sat[0] = 0; m_sat[1] = 0; m_wb = 0; m_wbc = 0; m_shf = 0;
        rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
        compare("R1");
    endtask

    task automatic t_multiply;
        c_frac = 0; c_uns = 0;
        do_op(2, 0, 16'd3, -16'sd5, 0, "R2");
        chk("R2", "literal", longint'($signed(acc_a)), -15);
        do_op(3, 1, 16'h1234, 16'h0100, 0, "R2");
        c_uns = 1; do_op(2, 0, 16'hFFFF, 16'h0002, 0, "R2");
        c_uns = 0; c_frac = 1; do_op(2, 1, 16'h4000, 16'h4000, 0, "R2");
        chk("R2", "literal_frac", longint'($signed(acc_b)), 64'h2000_0000);
        c_frac = 0;
    endtask

    task automatic t_mac;
        do_op(4, 0, 16'd100, 16'd7, 0, "R3");
        do_op(5, 0, -16'sd20, 16'd9, 0, "R3");
        do_op(5, 1, 16'h7FFF, 16'h7FFF, 0, "R3");
    endtask

    task automatic t_sqdiff;
        do_op(6, 0, 16'd10, 16'd3, 0, "R4");
        chk("R4", "literal", longint'($signed(acc_a)), 49);
        do_op(7, 0, -16'sd2, 16'd5, 0, "R4");
        c_uns = 1; do_op(6, 1, 16'hFFFF, 16'h0000, 0, "R4"); c_uns = 0;
        c_frac = 1; do_op(7, 1, 16'h8000, 16'h7FFF, 0, "R4"); c_frac = 0;
    endtask

    task automatic t_hold_clear;
        do_op(0, 0, 16'd9, 16'd9, 0, "R5");
        do_op(13, 1, 16'd9, 16'd9, 5, "R5");
        do_op(15, 0, 16'd1, 16'd1, 0, "R5");
        do_op(1, 0, 16'd0, 16'd0, 0, "R5");
    endtask

    task automatic t_accops;
        do_op(2, 0, 16'd1000, 16'd33, 0, "R6");
        do_op(2, 1, -16'sd400, 16'd21, 0, "R6");
        do_op(8, 0, 16'd0, 16'd0, 0, "R6");
        do_op(9, 1, 16'd0, 16'd0, 0, "R6");
        do_op(10, 0, 16'd0, 16'd0, 0, "R6");
    endtask

    task automatic t_shift;
        do_op(2, 0, 16'h1234, 16'h0001, 0, "R7");
        do_op(11, 0, 16'd0, 16'd0, 8, "R7");
        do_op(11, 0, 16'd0, 16'd0, -4, "R7");
        do_op(11, 0, 16'd0, 16'd0, -20, "R7");
        do_op(11, 0, 16'd0, 16'd0, 20, "R7");
        do_op(2, 1, -16'sd3, 16'd1, 0, "R7");
        do_op(11, 1, 16'd0, 16'd0, -16, "R7");
    endtask

    task automatic t_sat;
        c_frac = 1; c_sat_a = 1; c_wide = 0;
        do_op(1, 0, 16'd0, 16'd0, 0, "R8");
        do_op(2, 0, 16'h7FFF, 16'h7FFF, 0, "R8");
        do_op(4, 0, 16'h7FFF, 16'h7FFF, 0, "R8");
        chk("R8", "literal_narrow", longint'($signed(acc_a)), 64'h7FFF_FFFF);
        do_op(5, 0, 16'd1, 16'd1, 0, "R8");
        do_op(3, 0, 16'h7FFF, 16'h7FFF, 0, "R8");
        do_op(5, 0, 16'h7FFF, 16'h7FFF, 0, "R8");
        do_op(1, 0, 16'd0, 16'd0, 0, "R8");
        c_wide = 1; c_sat_b = 1;
        do_op(2, 1, 16'h7FFF, 16'h7FFF, 0, "R8");
        do_op(11, 1, 16'd0, 16'd0, 16, "R8");
        do_op(11, 1, 16'd0, 16'd0, 16, "R8");
        chk("R8", "literal_wide", longint'($signed(acc_b)), 64'h7F_FFFF_FFFF);
        do_op(10, 1, 16'd0, 16'd0, 0, "R8");
        do_op(1, 1, 16'd0, 16'd0, 0, "R8");
        c_sat_a = 0; c_sat_b = 0; c_wide = 0;
    endtask

    task automatic t_wrap;
        c_frac = 1;
        do_op(2, 1, 16'h7FFF, 16'h7FFF, 0, "R9");
        do_op(4, 1, 16'h7FFF, 16'h7FFF, 0, "R10");
        do_op(11, 1, 16'd0, 16'd0, 16, "R9");
        do_op(11, 1, 16'd0, 16'd0, 16, "R9");
        do_op(3, 0, 16'h7FFF, 16'h7FFF, 0, "R10");
        do_op(5, 0, 16'h7FFF, 16'h7FFF, 0, "R10");
        c_frac = 0;
    endtask

    task automatic t_round;
        c_conv = 0;
        do_op(2, 0, 16'h0080, 16'h0100, 0, "R11");
        do_op(2, 0, 16'h0180, 16'h0100, 0, "R11");
        c_conv = 1;
        do_op(2, 0, 16'h0080, 16'h0100, 0, "R11");
        chk("R11", "literal_even", longint'(wb_word), 0);
        do_op(2, 0, 16'h0180, 16'h0100, 0, "R11");
        chk("R11", "literal_odd", longint'(wb_word), 2);
        do_op(2, 0, 16'h0081, 16'h0100, 0, "R11");
        do_op(3, 1, 16'h0180, 16'h0100, 0, "R11");
        c_conv = 0;
    endtask

    task automatic t_wbsat;
        c_frac = 1; c_sat_wb = 1;
        do_op(2, 0, 16'h7FFF, 16'h7FFF, 0, "R12");
        do_op(4, 0, 16'h7FFF, 16'h7FFF, 0, "R12");
        chk("R12", "literal_pos", longint'(wb_word), 16'h7FFF);
        do_op(3, 1, 16'h7FFF, 16'h7FFF, 0, "R12");
        do_op(5, 1, 16'h7FFF, 16'h7FFF, 0, "R12");
        c_sat_wb = 0;
        do_op(0, 1, 16'd0, 16'd0, 0, "R12");
        c_frac = 0;
    endtask

    task automatic t_idle;
        @(negedge clk);
        op_valid = 0; op_code = 4'd1; acc_sel = 0; x_in = 16'd5; y_in = 16'd5;
        @(negedge clk); @(negedge clk);
        compare("R13");
        do_op(2, 0, 16'd77, 16'd3, 0, "R13");
        do_op(2, 1, 16'd11, 16'd2, 0, "R13");
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_multiply();
        t_mac();
        t_sqdiff();
        t_hold_clear();
        t_accops();
        t_shift();
        t_sat();
        t_wrap();
        t_round();
        t_wbsat();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule